// File: doc/BRIEF.md
# Power-on, semi-suspend and watchdog reset sequencer

This block decides when a small microcontroller core may run. While the supply-good input is low, or while the oscillator has not yet settled, it holds the system in power-on reset. Once both are good it releases the reset but keeps the processor stalled in a semi-suspend phase. The rest of the chip already runs during this phase, which gives the supply and the clock multiplier time to settle. The phase has a short guard window in which nothing can end it, followed by a long window that an upstream USB bus reset can cut short. When a bus reset ends the wait, the block leaves an interrupt request pending so that firmware can service it later.

Once the processor runs, a watchdog counts clock cycles. Firmware restarts it by writing any value to a fixed register address. If the watchdog is left alone for too long, the block issues a reset of fixed length and then lets the processor start again at address zero, with no second semi-suspend. The block also holds the reset-cause byte of the processor status register. Millisecond timing comes from a prescaler sized by a cycles-per-millisecond parameter. The supply-good and bus-reset inputs each pass through a two-flop synchroniser before use.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `vcc_ok_i` is low, or `osc_ok_i` is low, `sys_rst_o` is 1, `cpu_hold_o` is 0, `bus_rst_pend_o` is 0 and `stat_o` is 0x11 (bit 4 marks power-on, bit 0 is set). Once both inputs are high, reset is released within three clock cycles.
- R2: After release, `cpu_hold_o` stays 1 and `sys_rst_o` stays 0 for (HOLD_MS + SEMI_MS) milliseconds. After that, both are 0.
- R3: A bus-reset pulse that arrives during the first HOLD_MS milliseconds of semi-suspend has no effect: `cpu_hold_o` stays 1 and `bus_rst_pend_o` stays 0.
- R4: A bus-reset pulse during the later SEMI_MS window ends the hold three cycles after the pulse and sets `bus_rst_pend_o`.
- R5: Once set, the pending flag stays set until the processor writes address 0x20 with data bit 0 equal to 1. A write to 0x20 with bit 0 equal to 0 leaves it set. A watchdog reset also clears it.
- R6: A fall of `vcc_ok_i` forces power-on reset at once, without waiting for a clock edge. When `vcc_ok_i` returns, the whole sequence from R1 and R2 repeats.
- R7: While running, a write to address 0x26 clears the watchdog whatever the data. A write to any other address does not clear it. A write to 0x26 in the same cycle the count would roll over prevents the watchdog reset.
- R8: If the watchdog is not cleared for WDOG_MS milliseconds, `sys_rst_o` rises and stays 1 for WDR_MS milliseconds. Execution then resumes (`sys_rst_o` 0, `cpu_hold_o` 0) with no semi-suspend.
- R9: A watchdog reset loads `stat_o` with {0,1,0,previous bit 4,0,0,0,1}, so bit 6 marks a watchdog event. While running, a write to address 0xFF loads `stat_o` with the written data.
- R10: The watchdog is held cleared and stopped during power-on reset, semi-suspend and watchdog reset. No watchdog reset occurs during a semi-suspend longer than WDOG_MS.

Reset of the processor's registers, stack pointers, device address and interrupt enables is carried to them by `sys_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| vcc_ok_i | input | 1 | Supply-good indication, asynchronous, active high |
| osc_ok_i | input | 1 | Oscillator-stable flag, synchronous to clk |
| usb_bus_rst_i | input | 1 | Upstream bus-reset detect pulse |
| wr_en_i | input | 1 | Register write strobe from the processor |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| sys_rst_o | output | 1 | System reset, active high |
| cpu_hold_o | output | 1 | Processor stall during semi-suspend |
| bus_rst_pend_o | output | 1 | Pending bus-reset interrupt request |
| stat_o | output | 8 | Reset-cause byte of the processor status register |

## Verification
Two events can fall in the same cycle: the watchdog reaching its last count and a firmware restart write. The bench provokes this by placing a write to 0x26 so that it is sampled on exactly the edge where the count sits at its limit. The restart must win. A lost write would start a reset, and the bench would see `sys_rst_o` high a few cycles later. The bench instead expects it low, and it expects the next reset a full watchdog period after that edge. A second pairing is a status-register write close to a watchdog reset. Here the reset pattern must show the bit 4 that firmware just wrote.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_POR  = 3'd0,
        ST_LOCK = 3'd1,
        ST_SEMI = 3'd2,
        ST_RUN  = 3'd3,
        ST_WDR  = 3'd4
    } seq_state_e;

    localparam logic [7:0] STAT_POR = 8'h11;

    // Status byte written when the watchdog fires; bit 4 is carried over.
    function automatic logic [7:0] stat_after_wdr(input logic por_bit);
        return {3'b010, por_bit, 4'b0001};
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rstseq_tick.sv
module rstseq_tick #(
    parameter int CYC = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = (clr || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == '0);
endmodule

// File: rtl/rstseq_wdog.sv
module rstseq_wdog #(
    parameter int LIMIT = 96000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && !kick && (cnt_q == LAST);
        if (!run || kick || expire) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7
    kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> cnt_q == '0);

    // R10
    idle_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int CYC_PER_MS  = 12000,
    parameter int HOLD_MS     = 1,
    parameter int SEMI_MS     = 95,
    parameter int WDOG_MS     = 8,
    parameter int WDR_MS      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] WDOG_ADDR = 'h26,
    parameter logic [ADDR_W-1:0] IEN_ADDR  = 'h20,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 'hFF
) (
    input  logic              clk,
    input  logic              vcc_ok_i,
    input  logic              osc_ok_i,
    input  logic              usb_bus_rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic              sys_rst_o,
    output logic              cpu_hold_o,
    output logic              bus_rst_pend_o,
    output logic [7:0]        stat_o
);
    localparam int MAX_A = (HOLD_MS > SEMI_MS) ? HOLD_MS : SEMI_MS;
    localparam int MAX_MS = (MAX_A > WDR_MS) ? MAX_A : WDR_MS;
    localparam int MSW = (MAX_MS > 1) ? $clog2(MAX_MS) : 1;
    localparam logic [MSW-1:0] HOLD_LAST = MSW'(HOLD_MS - 1);
    localparam logic [MSW-1:0] SEMI_LAST = MSW'(SEMI_MS - 1);
    localparam logic [MSW-1:0] WDR_LAST  = MSW'(WDR_MS - 1);
    localparam int WDOG_CYC = WDOG_MS * CYC_PER_MS;

    typedef struct packed {
        seq_state_e       st;
        logic [MSW-1:0]   ms;
        logic             pend;
        logic [7:0]       stat;
    } regs_t;

    regs_t r_d, r_q;

    logic vcc_s, bus_s;
    logic tick, tick_clr;
    logic wd_run, wd_kick, wd_expire;
    logic ien_wr, stat_wr, state_chg;

    // Reset synchroniser: asserts at once, releases after SYNC_STAGES edges.
    rstseq_sync #(.STAGES(SYNC_STAGES)) u_vcc_sync (
        .clk    (clk),
        .arst_n (vcc_ok_i),
        .d      (1'b1),
        .q      (vcc_s)
    );

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_bus_sync (
        .clk    (clk),
        .arst_n (vcc_s),
        .d      (usb_bus_rst_i),
        .q      (bus_s)
    );

    rstseq_tick #(.CYC(CYC_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (vcc_s),
        .clr   (tick_clr),
        .tick  (tick)
    );

    rstseq_wdog #(.LIMIT(WDOG_CYC)) u_wdog (
        .clk    (clk),
        .rst_n  (vcc_s),
        .run    (wd_run),
        .kick   (wd_kick),
        .expire (wd_expire)
    );

    always_comb begin
        wd_run  = (r_q.st == ST_RUN);
        wd_kick = wr_en_i && (wr_addr_i == WDOG_ADDR);
        ien_wr  = wr_en_i && (wr_addr_i == IEN_ADDR);
        stat_wr = wr_en_i && (wr_addr_i == STAT_ADDR);
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_POR: begin
                if (osc_ok_i) r_d.st = ST_LOCK;
            end
            ST_LOCK: begin
                if (tick && r_q.ms == HOLD_LAST) r_d.st = ST_SEMI;
            end
            ST_SEMI: begin
                if (bus_s) begin
                    r_d.st   = ST_RUN;
                    r_d.pend = 1'b1;
                end else if (tick && r_q.ms == SEMI_LAST) begin
                    r_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (ien_wr && wr_data_i[0]) r_d.pend = 1'b0;
                if (stat_wr)                r_d.stat = wr_data_i;
                if (wd_expire) begin
                    r_d.st   = ST_WDR;
                    r_d.pend = 1'b0;
                    r_d.stat = stat_after_wdr(r_q.stat[4]);
                end
            end
            ST_WDR: begin
                if (tick && r_q.ms == WDR_LAST) r_d.st = ST_RUN;
            end
            default: r_d.st = ST_POR;
        endcase

        state_chg = (r_d.st != r_q.st);
        if (state_chg)  r_d.ms = '0;
        else if (tick)  r_d.ms = r_q.ms + 1'b1;

        tick_clr = state_chg || (r_q.st == ST_POR) || (r_q.st == ST_RUN);
    end

    always_ff @(posedge clk or negedge vcc_s) begin
        if (!vcc_s) begin
            r_q.st   <= ST_POR;
            r_q.ms   <= '0;
            r_q.pend <= 1'b0;
            r_q.stat <= STAT_POR;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        sys_rst_o      = (r_q.st == ST_POR) || (r_q.st == ST_WDR);
        cpu_hold_o     = (r_q.st == ST_LOCK) || (r_q.st == ST_SEMI);
        bus_rst_pend_o = r_q.pend;
        stat_o         = r_q.stat;
    end

    // R1
    osc_wait_chk: assert property (@(posedge clk) disable iff (!vcc_s)
        (r_q.st == ST_POR && !osc_ok_i) |=> r_q.st == ST_POR);

    // R2
    rst_hold_excl_chk: assert property (@(posedge clk) disable iff (!vcc_s)
        !(sys_rst_o && cpu_hold_o));

    // R3
    lock_ignores_bus_chk: assert property (@(posedge clk) disable iff (!vcc_s)
        (r_q.st == ST_LOCK) |=> r_q.st != ST_RUN);

    // R4
    semi_abort_chk: assert property (@(posedge clk) disable iff (!vcc_s)
        (r_q.st == ST_SEMI && bus_s) |=> (r_q.st == ST_RUN && r_q.pend));

    // R5
    pend_release_chk: assert property (@(posedge clk) disable iff (!vcc_s)
        $fell(r_q.pend) |-> ($past(ien_wr && wr_data_i[0]) || r_q.st == ST_WDR));

    // R8
    wdog_fire_chk: assert property (@(posedge clk) disable iff (!vcc_s)
        (r_q.st == ST_RUN && wd_expire) |=> (r_q.st == ST_WDR && sys_rst_o));

    // R9
    wdr_stat_chk: assert property (@(posedge clk) disable iff (!vcc_s)
        (r_q.st == ST_WDR && $past(r_q.st) == ST_RUN)
        |-> stat_o == {3'b010, $past(r_q.stat[4]), 4'b0001});
endmodule

// File: tb/rstseq_ctrl_tb.sv
module rstseq_ctrl_tb;
    localparam int CPM = 10;

    logic       clk = 1'b0;
    logic       vcc_ok = 1'b0;
    logic       osc_ok = 1'b0;
    logic       bus_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       sys_rst, cpu_hold, pend;
    logic [7:0] stat;

    rstseq_ctrl #(.CYC_PER_MS(CPM)) u_dut (
        .clk            (clk),
        .vcc_ok_i       (vcc_ok),
        .osc_ok_i       (osc_ok),
        .usb_bus_rst_i  (bus_rst),
        .wr_en_i        (wr_en),
        .wr_addr_i      (wr_addr),
        .wr_data_i      (wr_data),
        .sys_rst_o      (sys_rst),
        .cpu_hold_o     (cpu_hold),
        .bus_rst_pend_o (pend),
        .stat_o         (stat)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        int         sel;
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t sb_q[$];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam int S_RST = 0, S_HOLD = 1, S_PEND = 2, S_STAT = 3;

    function automatic logic [7:0] observe(input int sel);
        case (sel)
            S_RST:   return {7'd0, sys_rst};
            S_HOLD:  return {7'd0, cpu_hold};
            S_PEND:  return {7'd0, pend};
            default: return stat;
        endcase
    endfunction

    task automatic expect_at(input int at, input int sel, input logic [7:0] v, input string req);
        exp_t e;
        e.at = at; e.sel = sel; e.val = v; e.req = req;
        sb_q.push_back(e);
    endtask

    // Monitor: pops expected items when their cycle comes up.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            exp_t e;
            logic [7:0] got;
            e = sb_q.pop_front();
            n_run++;
            got = observe(e.sel);
            if (e.at != cyc) begin
                n_fail++;
                $display("FAIL %s: check for cycle %0d missed (actual cycle %0d, expected cycle %0d)",
                         e.req, e.at, cyc, e.at);
            end else if (got !== e.val) begin
                n_fail++;
                $display("FAIL %s: cycle %0d signal %0d actual %h expected %h",
                         e.req, cyc, e.sel, got, e.val);
            end
        end
    end

    task automatic goto(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_pulse();
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
    endtask

    localparam int L  = 18;
    localparam int R0 = L + 96 * CPM;
    localparam int P  = R0 + 100;
    localparam int Q  = P + 221;
    localparam int T1 = Q + 120;

    initial begin
        // R1 reset state and oscillator wait
        expect_at(3, S_RST, 1, "R1"); expect_at(3, S_HOLD, 0, "R1");
        expect_at(3, S_PEND, 0, "R1"); expect_at(3, S_STAT, 8'h11, "R1");
        expect_at(15, S_RST, 1, "R1"); expect_at(15, S_HOLD, 0, "R1");
        expect_at(L + 2, S_RST, 0, "R2"); expect_at(L + 2, S_HOLD, 1, "R2");
        // R3 bus reset in guard window ignored
        expect_at(L + 8, S_HOLD, 1, "R3");
        expect_at(L + 20, S_HOLD, 1, "R3"); expect_at(L + 20, S_PEND, 0, "R3");
        // R10 no watchdog reset during long semi-suspend
        expect_at(L + 500, S_RST, 0, "R10"); expect_at(L + 500, S_HOLD, 1, "R10");
        // R2 hold ends on time
        expect_at(R0 - 3, S_HOLD, 1, "R2");
        expect_at(R0 + 3, S_HOLD, 0, "R2"); expect_at(R0 + 3, S_RST, 0, "R2");
        expect_at(R0 + 3, S_PEND, 0, "R2");
        // R8/R9 first watchdog reset
        expect_at(R0 + 77, S_RST, 0, "R8");
        expect_at(R0 + 83, S_RST, 1, "R8"); expect_at(R0 + 83, S_STAT, 8'h51, "R9");
        expect_at(R0 + 83, S_HOLD, 0, "R8");
        expect_at(R0 + 97, S_RST, 1, "R8");
        expect_at(P + 3, S_RST, 0, "R8"); expect_at(P + 3, S_HOLD, 0, "R8");
        // R7 restarts, coincident restart, foreign address
        expect_at(P + 85, S_RST, 0, "R7");
        expect_at(P + 124, S_RST, 0, "R7");
        expect_at(P + 198, S_RST, 0, "R7");
        expect_at(P + 204, S_RST, 1, "R7"); expect_at(P + 204, S_STAT, 8'h51, "R9");
        expect_at(Q + 3, S_RST, 0, "R8");
        // R9 status write, then watchdog pattern with bit 4 cleared
        expect_at(Q + 8, S_STAT, 8'h00, "R9");
        expect_at(Q + 83, S_RST, 1, "R9"); expect_at(Q + 83, S_STAT, 8'h41, "R9");
        // R6 supply drop and return
        expect_at(Q + 111, S_RST, 1, "R6"); expect_at(Q + 111, S_HOLD, 0, "R6");
        expect_at(Q + 111, S_STAT, 8'h11, "R6"); expect_at(Q + 111, S_PEND, 0, "R6");
        expect_at(T1 + 5, S_RST, 0, "R6"); expect_at(T1 + 5, S_HOLD, 1, "R6");
        // R4 bus reset aborts semi-suspend
        expect_at(T1 + 101, S_HOLD, 1, "R4");
        expect_at(T1 + 105, S_HOLD, 0, "R4"); expect_at(T1 + 105, S_PEND, 1, "R4");
        expect_at(T1 + 105, S_RST, 0, "R4");
        // R5 pending flag release
        expect_at(T1 + 113, S_PEND, 1, "R5");
        expect_at(T1 + 118, S_PEND, 0, "R5");

        goto(5);        vcc_ok = 1'b1;
        goto(17);       osc_ok = 1'b1;
        goto(L + 2);    bus_pulse();
        goto(P + 40);   reg_write(8'h26, 8'hA5);
        goto(P + 120);  reg_write(8'h26, 8'h00);
        goto(P + 160);  reg_write(8'h27, 8'h00);
        goto(Q + 5);    reg_write(8'hFF, 8'h00);
        goto(Q + 110);  vcc_ok = 1'b0;
        goto(T1);       vcc_ok = 1'b1;
        goto(T1 + 100); bus_pulse();
        goto(T1 + 110); reg_write(8'h20, 8'hFE);
        goto(T1 + 115); reg_write(8'h20, 8'h01);
        goto(T1 + 125);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
        end
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 20000) @(negedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung at cycle %0d, expected end before 20000", cyc);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule